// File: doc/BRIEF.md
# Serial ADC Result Readout Master

This block is the clocked master side of a serial link to an analog-to-digital converter whose result is read out over a four-wire SPI-style port. A one-cycle start request opens a single chip-select window. Inside that window the block generates 24 serial clock periods, each sixteen system clocks long, and takes in 24 bits from the converter's data line. The window holds three byte-sized slots. The opening slot should read as zeros. The 14-bit result starts in the middle slot and runs into the last slot, and the last slot ends with two status bits that the block drops.

When the window closes, the block raises chip select again. On the following cycle it presents the right-justified 14-bit sample together with a one-cycle valid strobe. A frame-error flag comes with the strobe when the opening slot was not all zeros. A busy output covers the whole window, and any start request made while busy is high has no effect.

Top module: `adc_frame_reader`

## Requirements
- R1: One system cycle after a start request is sampled in idle, adc_cs_n goes low. It stays low for exactly 384 system cycles (24 serial periods of 16 cycles each) and then returns high.
- R2: adc_sclk is low whenever adc_cs_n is high. Inside the window, each serial period is low for the first 8 system cycles and high for the last 8, which gives 24 rising edges per frame.
- R3: The data line is sampled at the system edge on which adc_sclk rises. The converter changes its data only after adc_sclk falls, and the bits arrive most significant first.
- R4: Number the 24 received bits 23 (first) down to 0 (last). sample_data is then bits 15..2 as a right-justified 14-bit value. Bits 1 and 0, the trailing status pair, have no effect on sample_data.
- R5: sample_valid is a single-cycle pulse. It is raised one cycle after adc_cs_n returns high, and adc_cs_n is high in both of those cycles.
- R6: frame_err is updated together with sample_valid. It is 1 when any of received bits 23..16 is 1, and 0 when they are all 0.
- R7: A start request has no effect while busy is high. This includes the closing cycle in which adc_cs_n has just risen.
- R8: The data-line value while adc_cs_n is high has no effect on sample_data or frame_err.
- R9: busy rises in the same cycle that adc_cs_n falls. It stays high until, and falls in, the cycle that carries sample_valid.
- R10: A synchronous active-high rst, including one applied mid-frame, leads on the next edge to adc_cs_n=1, adc_sclk=0, busy=0, sample_valid=0, sample_data=0 and frame_err=0.
- R11: The sample_data and frame_err values are held unchanged between valid strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to read one conversion result |
| adc_sdo | input | 1 | Serial data from the converter |
| adc_cs_n | output | 1 | Active-low chip select to the converter |
| adc_sclk | output | 1 | Serial clock to the converter, idles low |
| busy | output | 1 | Frame in progress |
| sample_valid | output | 1 | One-cycle strobe marking a new result |
| sample_data | output | 14 | Right-justified 14-bit result |
| frame_err | output | 1 | Opening slot was not all zeros |

## Verification
The bench reads all-ones, all-zeros and two alternating-bit results, so a stuck, shifted or reversed bit position shows up as a different value. It sets the trailing status bits to ones on a zero result, which catches an extraction window that is off by one. A nonzero opening slot is followed by a clean frame, which checks both that the error flag is raised and that it is cleared again. Other runs toggle the data line while chip select is high, hold start high across whole frames and across the closing cycle, and reset in the middle of a window. A cycle-exact model compares every output on every clock, so timing slips in the divider or the window length are caught as well as wrong values.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

    typedef enum logic [1:0] {
        RD_IDLE = 2'd0,
        RD_RUN  = 2'd1,
        RD_DONE = 2'd2
    } rd_state_e;

endpackage

// File: rtl/adc_rd_clkdiv.sv
module adc_rd_clkdiv #(
    parameter int DIV = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic rise_tick,
    output logic fall_tick
);
    localparam int HALF = DIV / 2;
    localparam int CW   = (DIV > 2) ? $clog2(DIV) : 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
    } div_s;

    div_s q, d;

    always_comb begin
        d = q;
        if (!run)
            d.cnt = '0;
        else if (q.cnt == CW'(DIV - 1))
            d.cnt = '0;
        else
            d.cnt = q.cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    assign rise_tick = run && (q.cnt == CW'(HALF - 1));
    assign fall_tick = run && (q.cnt == CW'(DIV - 1));

    // R2
    div_range_chk: assert property (@(posedge clk) disable iff (rst)
        !run |=> q.cnt == '0);

endmodule

// File: rtl/adc_rd_shifter.sv
module adc_rd_shifter #(
    parameter int LEAD_W  = 8,
    parameter int RES_W   = 14,
    parameter int TRAIL_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             shift_en,
    input  logic             din,
    output logic [RES_W-1:0] result,
    output logic             lead_nonzero
);
    localparam int FRAME_W = LEAD_W + RES_W + TRAIL_W;

    typedef struct packed {
        logic [FRAME_W-1:0] sr;
    } shf_s;

    shf_s q, d;

    always_comb begin
        d = q;
        if (shift_en)
            d.sr = {q.sr[FRAME_W-2:0], din};
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    assign result       = q.sr[TRAIL_W +: RES_W];
    assign lead_nonzero = |q.sr[FRAME_W-1 -: LEAD_W];

    // R3
    sample_capture_chk: assert property (@(posedge clk) disable iff (rst)
        shift_en |=> q.sr[0] == $past(din));

endmodule

// File: rtl/adc_frame_reader.sv
module adc_frame_reader
    import adc_rd_pkg::*;
#(
    parameter int DIV     = 16,
    parameter int LEAD_W  = 8,
    parameter int RES_W   = 14,
    parameter int TRAIL_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             adc_sdo,
    output logic             adc_cs_n,
    output logic             adc_sclk,
    output logic             busy,
    output logic             sample_valid,
    output logic [RES_W-1:0] sample_data,
    output logic             frame_err
);
    localparam int FRAME_W = LEAD_W + RES_W + TRAIL_W;
    localparam int BCW     = $clog2(FRAME_W);

    typedef struct packed {
        rd_state_e        st;
        logic [BCW-1:0]   bits;
        logic             cs_n;
        logic             sclk;
        logic             busy;
        logic             valid;
        logic [RES_W-1:0] data;
        logic             ferr;
    } ctl_s;

    localparam ctl_s CTL_RST = '{st: RD_IDLE, bits: '0, cs_n: 1'b1, sclk: 1'b0,
                                 busy: 1'b0, valid: 1'b0, data: '0, ferr: 1'b0};

    ctl_s q, d;
    logic rise_tick, fall_tick;
    logic [RES_W-1:0] shf_result;
    logic shf_lead_nz;

    adc_rd_clkdiv #(.DIV(DIV)) u_div (
        .clk       (clk),
        .rst       (rst),
        .run       (q.st == RD_RUN),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick)
    );

    adc_rd_shifter #(.LEAD_W(LEAD_W), .RES_W(RES_W), .TRAIL_W(TRAIL_W)) u_shf (
        .clk          (clk),
        .rst          (rst),
        .shift_en     (rise_tick),
        .din          (adc_sdo),
        .result       (shf_result),
        .lead_nonzero (shf_lead_nz)
    );

    always_comb begin
        d       = q;
        d.valid = 1'b0;
        unique case (q.st)
            RD_IDLE: begin
                if (start) begin
                    d.st   = RD_RUN;
                    d.cs_n = 1'b0;
                    d.busy = 1'b1;
                    d.bits = '0;
                    d.sclk = 1'b0;
                end
            end
            RD_RUN: begin
                if (rise_tick)
                    d.sclk = 1'b1;
                if (fall_tick) begin
                    d.sclk = 1'b0;
                    if (q.bits == BCW'(FRAME_W - 1)) begin
                        d.st   = RD_DONE;
                        d.cs_n = 1'b1;
                    end else begin
                        d.bits = q.bits + 1'b1;
                    end
                end
            end
            RD_DONE: begin
                d.st    = RD_IDLE;
                d.busy  = 1'b0;
                d.valid = 1'b1;
                d.data  = shf_result;
                d.ferr  = shf_lead_nz;
            end
            default: d = CTL_RST;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) q <= CTL_RST;
        else     q <= d;
    end

    assign adc_cs_n     = q.cs_n;
    assign adc_sclk     = q.sclk;
    assign busy         = q.busy;
    assign sample_valid = q.valid;
    assign sample_data  = q.data;
    assign frame_err    = q.ferr;

    // R2
    sclk_idle_chk: assert property (@(posedge clk) disable iff (rst)
        adc_cs_n |-> !adc_sclk);

    // R5
    valid_after_cs_chk: assert property (@(posedge clk) disable iff (rst)
        sample_valid |-> (adc_cs_n && $past(adc_cs_n)));

    // R5
    valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        sample_valid |=> !sample_valid);

    // R9
    busy_with_cs_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(adc_cs_n) |-> busy);

    // R7
    start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        busy |=> !$fell(adc_cs_n));

    // R11
    data_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !sample_valid |=> (sample_valid || $stable(sample_data)));

    // R10
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (adc_cs_n && !adc_sclk && !busy && !sample_valid
                 && sample_data == '0 && !frame_err));

endmodule

// File: tb/test_adc_frame_reader.sv
module test_adc_frame_reader;
    localparam int CLK_PERIOD = 10;
    localparam int DIV        = 16;
    localparam int NBITS      = 24;
    localparam int CS_LOW     = DIV * NBITS;
    localparam int VALID_K    = CS_LOW + 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic noise = 1'b0;
    logic adc_sdo;
    logic adc_cs_n, adc_sclk, busy, sample_valid, frame_err;
    logic [13:0] sample_data;

    logic [23:0] send_word = '0;
    int idx = 23;
    logic prev_sclk = 1'b0;

    int checks = 0;
    int fails = 0;
    int cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    adc_frame_reader i_adc_frame_reader (
        .clk          (clk),
        .rst          (rst),
        .start        (start),
        .adc_sdo      (adc_sdo),
        .adc_cs_n     (adc_cs_n),
        .adc_sclk     (adc_sclk),
        .busy         (busy),
        .sample_valid (sample_valid),
        .sample_data  (sample_data),
        .frame_err    (frame_err)
    );

    // converter model: shifts on falling serial clock, noise while deselected
    always @(adc_cs_n, adc_sclk) begin
        if (adc_cs_n) idx = 23;
        else if (prev_sclk && !adc_sclk && idx > 0) idx = idx - 1;
        prev_sclk = adc_sclk;
    end
    assign adc_sdo = adc_cs_n ? noise : send_word[idx];

    // behavioural reference, checked every clock at the falling edge
    logic start_seen = 1'b0, rst_seen = 1'b1;
    bit running = 0;
    int k = 0;
    logic e_valid = 0, e_ferr = 0;
    logic [13:0] e_data = '0;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s at cycle %0d: actual %0h expected %0h", tag, cycles, act, exp);
        end
    endtask

    always @(negedge clk) begin
        logic e_cs, e_sclk, e_busy;
        cycles++;
        e_valid = 0;
        if (rst_seen) begin
            running = 0; k = 0; e_data = '0; e_ferr = 0;
        end else if (!running) begin
            if (start_seen) begin running = 1; k = 0; end
        end else begin
            k++;
            if (k == VALID_K) begin
                running = 0;
                e_valid = 1;
                e_data = send_word[15:2];
                e_ferr = |send_word[23:16];
            end
        end
        e_cs   = !(running && k < CS_LOW);
        e_sclk = running && k < CS_LOW && (k % DIV) >= DIV/2;
        e_busy = running;
        if (rst_seen) begin
            check("R10 cs_n", adc_cs_n, e_cs);
            check("R10 sclk", adc_sclk, e_sclk);
            check("R10 busy", busy, e_busy);
        end else begin
            check("R1 R7 cs_n", adc_cs_n, e_cs);
            check("R2 sclk", adc_sclk, e_sclk);
            check("R9 R7 busy", busy, e_busy);
            check("R5 valid", sample_valid, e_valid);
            check("R3 R4 R8 R11 data", sample_data, e_data);
            check("R6 R8 frame_err", frame_err, e_ferr);
        end
        start_seen = start;
        rst_seen = rst;
    end

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic frame(input logic [23:0] w, input bit hold_start);
        send_word = w;
        start = 1'b1;
        tick(1);
        if (!hold_start) start = 1'b0;
        tick(VALID_K + 2);
        start = 1'b0;
        tick(2);
    endtask

    task automatic idle_noise(input int n);
        for (int i = 0; i < n; i++) begin
            noise = ~noise;
            tick(1);
        end
        noise = 1'b0;
    endtask

    initial begin
        tick(3);
        rst = 1'b0;
        tick(3);
        // R4: full scale, zero, alternating patterns
        frame({8'h00, 14'h3FFF, 2'b00}, 0);
        frame({8'h00, 14'h0000, 2'b00}, 0);
        frame({8'h00, 14'h2AAA, 2'b01}, 0);
        frame({8'h00, 14'h1555, 2'b10}, 0);
        // R4: trailing status bits set, must be dropped
        frame({8'h00, 14'h0000, 2'b11}, 0);
        // R6: nonzero opening slot, then clean again
        frame({8'h80, 14'h1234, 2'b00}, 0);
        frame({8'h01, 14'h0ABC, 2'b11}, 0);
        frame({8'h00, 14'h0ABC, 2'b00}, 0);
        // R8: noisy data line while deselected, then a frame
        idle_noise(40);
        frame({8'h00, 14'h2001, 2'b01}, 0);
        idle_noise(20);
        // R7: start held high through whole frames and closing cycle
        frame({8'h00, 14'h3C3C, 2'b00}, 1);
        // R10: reset in the middle of a window
        send_word = {8'h00, 14'h1111, 2'b00};
        start = 1'b1;
        tick(1);
        start = 1'b0;
        tick(100);
        rst = 1'b1;
        tick(1);
        rst = 1'b0;
        tick(5);
        frame({8'h00, 14'h0F0F, 2'b10}, 0);
        tick(5);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        $display("FAIL watchdog expired: actual running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule